// File: doc/BRIEF.md
# I2C SCL Period Generator

This block derives the serial clock for an I2C master from the system clock. A 7-bit period setting selects a prescaled time unit of 2×(1+P) system clocks, where P is the setting. Each SCL cycle is asymmetric: six units low followed by four units high. One full SCL cycle therefore takes 20×(1+P) system clocks. With a 16 MHz system clock, P=7 gives 100 kbit/s and P=1 gives 400 kbit/s. A 1 Mbit/s rate is out of reach at that clock, because it would need a negative setting.

Alongside the SCL level, the block gives the bit engine two single-cycle strobes. One marks the safe point to change SDA, in the middle of the low portion. The other marks the point to sample SDA, in the middle of the high portion. The bit engine controls the generator with an enable and a halt request. Halt stops the clock only at the end of a high portion, so SCL is left high for stop and idle conditions. The period setting is captured only at the start of each SCL cycle. Slave clock stretching, high-speed mode, SDA driving and byte sequencing are not handled here.

Top module: `scl_period_gen`

## Requirements
- R1: During reset, and afterwards while `en` is 0, `scl` is 1 and both strobes are 0.
- R2: When `en` is raised with `halt` at 0, `scl` goes to 0 on the next clock edge. The first low portion has full length.
- R3: Each low portion of `scl` lasts 6 units of 2×(1+P) clocks, which is 12×(1+P) clocks. P is the value of `tpr` captured at the start of that cycle.
- R4: Each high portion of `scl` lasts 4 units, which is 8×(1+P) clocks.
- R5: A full SCL cycle takes 20×(1+P) clocks for every P from 0 to 127. P=7 gives 160 clocks and P=1 gives 40 clocks.
- R6: `sda_change` pulses for exactly one clock per low portion, 6×(1+P) clocks after the low portion starts (zero-based offset), and only while `scl` is 0.
- R7: `sda_sample` pulses for exactly one clock per high portion, 4×(1+P) clocks after the high portion starts (zero-based offset), and only while `scl` is 1.
- R8: A change on `tpr` in the middle of a cycle does not alter that cycle. It applies from the next low portion.
- R9: `halt` is acted on only at the end of a high portion. `scl` then stays at 1 while `halt` is held. When `halt` is released, a full low portion begins one clock later.
- R10: Dropping `en` forces `scl` to 1 on the next clock edge, abandoning the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run the generator; 0 forces idle at once |
| halt | input | 1 | Stop at the end of the current high portion |
| tpr | input | 7 | Period setting P; unit = 2×(1+P) clocks |
| scl | output | 1 | Serial clock level |
| sda_change | output | 1 | One-cycle strobe mid-low: SDA may change |
| sda_sample | output | 1 | One-cycle strobe mid-high: sample SDA |

## Verification
The bench measures the low length, the high length and the strobe offsets at the extremes of the period setting. P=0 is the shortest unit, so an off-by-one in the unit compare would show up as a 1-clock error on every unit. P=127 is the widest counter value, where a counter that is too narrow would wrap and give short periods. It changes `tpr` just after a cycle starts: a design that loads the setting at any time would stretch the low portion in progress. It raises `halt` early in a low portion. A design that honoured it at once would cut SCL short or park it low, and one that ignored it would start another low portion. It also drops `en` in mid-low, where a generator that finishes the cycle first would hold SCL low for extra clocks.

// File: rtl/scl_gen_pkg.sv
// Shared types for the SCL period generator.
package scl_gen_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;
endpackage

// File: rtl/scl_unit_timer.sv
// Prescaler: divides the system clock into units of 2*(1+P) cycles.
// Assumes tpr_cur is stable for the length of a unit. clr holds the count
// at zero so that the first unit after idle has full length.
module scl_unit_timer #(
    parameter int TPR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [TPR_W-1:0] tpr_cur,
    output logic             unit_tick,
    output logic             unit_first
);
    localparam int CNT_W = TPR_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Last count of a unit: 2*(1+P)-1 = 2P+1.
    always_comb begin
        last       = {tpr_cur, 1'b1};
        unit_tick  = (cnt == last);
        unit_first = (cnt == '0);
    end

    // Count system clocks within the current unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || unit_tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scl_phase_seq.sv
// Phase sequencer: walks idle -> low (LOW_UNITS) -> high (HIGH_UNITS).
// Captures the period setting only at the start of each SCL cycle. Honours
// halt only at the end of a high portion. A low enable idles at once.
module scl_phase_seq
    import scl_gen_pkg::*;
#(
    parameter int TPR_W      = 7,
    parameter int LOW_UNITS  = 6,
    parameter int HIGH_UNITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             halt,
    input  logic [TPR_W-1:0] tpr_in,
    input  logic             unit_tick,
    input  logic             unit_first,
    output scl_phase_e       phase,
    output logic [TPR_W-1:0] tpr_cur,
    output logic             chg_stb,
    output logic             smp_stb
);
    localparam int MAX_UNITS = (LOW_UNITS > HIGH_UNITS) ? LOW_UNITS : HIGH_UNITS;
    localparam int UNIT_W    = $clog2(MAX_UNITS);
    localparam logic [UNIT_W-1:0] LOW_LAST  = UNIT_W'(LOW_UNITS - 1);
    localparam logic [UNIT_W-1:0] HIGH_LAST = UNIT_W'(HIGH_UNITS - 1);
    localparam logic [UNIT_W-1:0] LOW_MID   = UNIT_W'(LOW_UNITS / 2);
    localparam logic [UNIT_W-1:0] HIGH_MID  = UNIT_W'(HIGH_UNITS / 2);

    scl_phase_e        ph_n;
    logic [UNIT_W-1:0] unit, unit_n;
    logic              load;

    // Next phase, next unit index and the period-capture decision.
    always_comb begin
        ph_n   = phase;
        unit_n = unit;
        load   = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (en && !halt) begin
                    ph_n   = PH_LOW;
                    unit_n = '0;
                    load   = 1'b1;
                end
            end
            PH_LOW: begin
                if (unit_tick) begin
                    if (unit == LOW_LAST) begin
                        ph_n   = PH_HIGH;
                        unit_n = '0;
                    end else begin
                        unit_n = unit + 1'b1;
                    end
                end
            end
            PH_HIGH: begin
                if (unit_tick) begin
                    if (unit == HIGH_LAST) begin
                        unit_n = '0;
                        if (halt) begin
                            ph_n = PH_IDLE;
                        end else begin
                            ph_n = PH_LOW;
                            load = 1'b1;
                        end
                    end else begin
                        unit_n = unit + 1'b1;
                    end
                end
            end
            default: begin
                ph_n   = PH_IDLE;
                unit_n = '0;
            end
        endcase
        if (!en) begin
            ph_n   = PH_IDLE;
            unit_n = '0;
            load   = 1'b0;
        end
    end

    // Phase, unit index and captured period registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            unit    <= '0;
            tpr_cur <= '0;
        end else begin
            phase <= ph_n;
            unit  <= unit_n;
            if (load) begin
                tpr_cur <= tpr_in;
            end
        end
    end

    // Strobes: first clock of the middle unit of each portion.
    always_comb begin
        chg_stb = (phase == PH_LOW)  && (unit == LOW_MID)  && unit_first;
        smp_stb = (phase == PH_HIGH) && (unit == HIGH_MID) && unit_first;
    end
endmodule

// File: rtl/scl_period_gen.sv
// SCL period generator top: a unit prescaler plus a phase sequencer.
// SCL is low only in the low phase, so it rests high when idle or halted.
// Assumes en, halt and tpr are synchronous to clk.
module scl_period_gen
    import scl_gen_pkg::*;
#(
    parameter int TPR_W      = 7,
    parameter int LOW_UNITS  = 6,
    parameter int HIGH_UNITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             halt,
    input  logic [TPR_W-1:0] tpr,
    output logic             scl,
    output logic             sda_change,
    output logic             sda_sample
);
    scl_phase_e       phase;
    logic [TPR_W-1:0] tpr_cur;
    logic             unit_tick;
    logic             unit_first;
    logic             chg_stb;
    logic             smp_stb;

    scl_unit_timer #(.TPR_W(TPR_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (phase == PH_IDLE),
        .tpr_cur    (tpr_cur),
        .unit_tick  (unit_tick),
        .unit_first (unit_first)
    );

    scl_phase_seq #(
        .TPR_W      (TPR_W),
        .LOW_UNITS  (LOW_UNITS),
        .HIGH_UNITS (HIGH_UNITS)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .halt       (halt),
        .tpr_in     (tpr),
        .unit_tick  (unit_tick),
        .unit_first (unit_first),
        .phase      (phase),
        .tpr_cur    (tpr_cur),
        .chg_stb    (chg_stb),
        .smp_stb    (smp_stb)
    );

    // Output levels and strobes.
    always_comb begin
        scl        = (phase != PH_LOW);
        sda_change = chg_stb;
        sda_sample = smp_stb;
    end
endmodule

// File: rtl/scl_period_gen_chk.sv
// Checker for the SCL period generator; attached through bind.
module scl_period_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic halt,
    input logic scl,
    input logic sda_change,
    input logic sda_sample
);
    // R10: a low enable leaves SCL high on the next clock.
    a_r10_disable_high: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> scl);

    // R6: the change strobe only occurs while SCL is low.
    a_r6_change_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change |-> !scl);

    // R6: the change strobe is a single-clock pulse.
    a_r6_change_single: assert property (@(posedge clk) disable iff (!rst_n)
        sda_change |=> !sda_change);

    // R7: the sample strobe only occurs while SCL is high.
    a_r7_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample |-> scl);

    // R7: the sample strobe is a single-clock pulse.
    a_r7_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample |=> !sda_sample);

    // R9: while halt is requested, a high SCL never drops.
    a_r9_halt_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && scl) |=> scl);
endmodule

bind scl_period_gen scl_period_gen_chk i_chk (.*);

// File: tb/test_scl_period_gen.sv
`timescale 1ns/1ps
module test_scl_period_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic       halt;
    logic [6:0] tpr;
    logic       scl;
    logic       sda_change;
    logic       sda_sample;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    // {P, expected low clocks, expected high clocks}
    localparam int NV = 5;
    localparam int VEC [NV][3] = '{
        '{0,   12,   8},
        '{1,   24,   16},
        '{3,   48,   32},
        '{7,   96,   64},
        '{127, 1536, 1024}
    };

    scl_period_gen i_scl_period_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .halt       (halt),
        .tpr        (tpr),
        .scl        (scl),
        .sda_change (sda_change),
        .sda_sample (sda_sample)
    );

    always #2 clk = ~clk;

    // Watchdog: counts as a failed check and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run = n_run + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        en    = 1'b0;
        halt  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Length of the run of scl == lvl starting at the current sample.
    task automatic run_len(input logic lvl, input int cap, output int n);
        n = 0;
        while (scl === lvl && n < cap) begin
            n = n + 1;
            @(negedge clk);
        end
    endtask

    // Measure one full SCL cycle from its falling edge.
    task automatic measure(output int lo, output int hi, output int c_off,
                           output int s_off, output int c_cnt, output int s_cnt);
        int guard;
        guard = 0;
        lo = 0; hi = 0; c_off = -1; s_off = -1; c_cnt = 0; s_cnt = 0;
        while (scl !== 1'b0 && guard < 5000) begin
            guard = guard + 1;
            @(negedge clk);
        end
        while (scl === 1'b0 && lo < 5000) begin
            if (sda_change) begin c_off = lo; c_cnt = c_cnt + 1; end
            if (sda_sample) s_cnt = s_cnt + 1;
            lo = lo + 1;
            @(negedge clk);
        end
        while (scl === 1'b1 && hi < 5000) begin
            if (sda_sample) begin s_off = hi; s_cnt = s_cnt + 1; end
            if (sda_change) c_cnt = c_cnt + 1;
            hi = hi + 1;
            @(negedge clk);
        end
    endtask

    initial begin
        int lo, hi, c_off, s_off, c_cnt, s_cnt, n, strobes;
        tpr = 7'd0;

        // R1: reset state.
        rst_n = 1'b0; en = 1'b1; halt = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 scl in reset", int'(scl), 1);
        check("R1 strobes in reset", int'(sda_change) + int'(sda_sample), 0);
        do_reset();
        strobes = 0; n = 0;
        for (int k = 0; k < 50; k++) begin
            if (scl === 1'b1) n = n + 1;
            strobes = strobes + int'(sda_change) + int'(sda_sample);
            @(negedge clk);
        end
        check("R1 scl high while disabled", n, 50);
        check("R1 no strobes while disabled", strobes, 0);

        // Vector table: R2-R7 across the period range.
        for (int i = 0; i < NV; i++) begin
            do_reset();
            tpr = 7'(VEC[i][0]);
            en  = 1'b1;
            @(negedge clk);
            check("R2 scl low one clock after enable", int'(scl), 0);
            measure(lo, hi, c_off, s_off, c_cnt, s_cnt);
            check("R2 R3 first low length", lo, VEC[i][1]);
            check("R4 high length", hi, VEC[i][2]);
            check("R6 change offset", c_off, VEC[i][1] / 2);
            check("R6 change count", c_cnt, 1);
            check("R7 sample offset", s_off, VEC[i][2] / 2);
            check("R7 sample count", s_cnt, 1);
            measure(lo, hi, c_off, s_off, c_cnt, s_cnt);
            check("R5 second period", lo + hi, 20 * (1 + VEC[i][0]));
        end

        // R8: period change just after a cycle starts.
        do_reset();
        tpr = 7'd1; en = 1'b1;
        @(negedge clk);
        tpr = 7'd3;
        run_len(1'b0, 5000, lo);
        run_len(1'b1, 5000, hi);
        check("R8 running low unchanged", lo, 24);
        check("R8 running high unchanged", hi, 16);
        measure(lo, hi, c_off, s_off, c_cnt, s_cnt);
        check("R8 next period uses new value", lo + hi, 80);

        // R9: halt requested early in a low portion.
        do_reset();
        tpr = 7'd0; en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        halt = 1'b1;
        run_len(1'b0, 5000, lo);
        check("R9 low completes under halt", lo + 1, 12);
        run_len(1'b1, 300, hi);
        check("R9 scl held high while halted", hi, 300);
        halt = 1'b0;
        @(negedge clk);
        check("R9 resume low one clock after release", int'(scl), 0);
        run_len(1'b0, 5000, lo);
        check("R9 full low after release", lo, 12);

        // R10: enable dropped in the middle of a low portion.
        do_reset();
        tpr = 7'd3; en = 1'b1;
        repeat (10) @(negedge clk);
        check("R10 low before drop", int'(scl), 0);
        en = 1'b0;
        @(negedge clk);
        check("R10 scl high one clock after drop", int'(scl), 1);
        strobes = 0; n = 0;
        for (int k = 0; k < 100; k++) begin
            if (scl === 1'b1) n = n + 1;
            strobes = strobes + int'(sda_change) + int'(sda_sample);
            @(negedge clk);
        end
        check("R10 stays high", n, 100);
        check("R10 no strobes after drop", strobes, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule